// File: doc/BRIEF.md
# Split-Counter Counter-Mode Cache-Line Cipher

This block sits in a memory controller path and applies counter-mode encryption to 64-byte cache lines. A write-back request carries plaintext and leaves as ciphertext. A read-fill request carries ciphertext and leaves as plaintext. Both directions use the same operation: a keystream pad is XORed with the data.

Each line has a write counter, and that counter advances on every write-back. Because of this, writing the same plaintext to the same line twice gives two unrelated ciphertexts. The counters are stored in split form. Every group of 64 lines shares one wide major counter, and each line also keeps its own narrow minor counter. The minor counters live in a RAM that can be inferred as block RAM. The major counters are held in flops.

For each of the four 128-bit blocks of a line, the block builds a seed from four fields: the line address, the major counter, the minor counter and a block index. It hands the seed to an external block-cipher unit over a valid/ready handshake. It then waits for that unit's keystream word before it moves on.

When a minor counter wraps, three things happen. The group's major counter advances, every minor counter in the group returns to zero, and a request to re-encrypt the group is raised. Requests are served one at a time and in order, and `busy` blocks new requests.

Top module: `ctr_line_crypt`

## Requirements
- R1: After reset, `busy` stays high while every minor counter is cleared, which takes at least 256 cycles. After that, all counters read zero, so the first write-back to any line uses major 0 and minor 1.
- R2: `seed_data` is made of four fields. The line address is in bits [72:65], the major counter in [64:9], the minor counter in [8:2] and the block index in [1:0]. For each request, the block index takes the values 0, 1, 2 and 3 in that order.
- R3: A write-back increments the line's minor counter before using it. The n-th write-back to a line since its group was last cleared uses minor n, so repeated identical plaintext produces different ciphertext.
- R4: A read-fill uses the line's current counter and leaves that counter unchanged. A read-fill does not raise `cnt_valid`.
- R5: Output block j is `out_data[128j+127:128j]`. It equals input block j XOR the keystream word returned for the seed whose block index is j.
- R6: A write-back raises `cnt_valid` in the same cycle as its `out_valid`. At that point `cnt_addr`, `cnt_major` and `cnt_minor` give the counter used.
- R7: A write-back to a line whose minor counter is 127 does the following. It uses major+1 and minor 0. It raises `regroup_valid` with `regroup_group` = address bits [7:6]. It leaves every line of that group at minor 0 under the new major.
- R8: A wrap in one group leaves the counters of the other groups unchanged.
- R9: A request is accepted only when `busy` is low. Requests presented while `busy` is high are ignored and change no counter. Each accepted request gives exactly one single-cycle `out_valid`, in acceptance order. At most one seed is outstanding at a time.
- R10: While `seed_valid` is high and `seed_ready` is low, `seed_valid` stays high and `seed_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write-back (encrypt), 0 = read-fill (decrypt) |
| req_addr | input | 8 | Line address |
| req_data | input | 512 | Line data |
| busy | output | 1 | Block cannot accept a request |
| seed_valid | output | 1 | Seed offered to the cipher unit |
| seed_ready | input | 1 | Cipher unit takes the seed |
| seed_data | output | 73 | Address, major, minor and block index |
| ks_valid | input | 1 | Keystream word present |
| ks_data | input | 128 | Keystream word |
| out_valid | output | 1 | Processed line present |
| out_write | output | 1 | Direction of the processed line |
| out_addr | output | 8 | Address of the processed line |
| out_data | output | 512 | Processed line |
| cnt_valid | output | 1 | Counter-update notification |
| cnt_addr | output | 8 | Line whose counter was updated |
| cnt_major | output | 56 | Major counter used |
| cnt_minor | output | 7 | Minor counter used |
| regroup_valid | output | 1 | Group needs re-encryption |
| regroup_group | output | 2 | Group index |

## Verification
The assertions rely on three assumptions about the cipher unit. It returns exactly one keystream word per accepted seed. It raises `ks_valid` only after that seed's handshake. It holds `seed_ready` only in answer to a seed it is taking. The bench's responder keeps to these rules. It waits a varying number of cycles before it takes each seed and before it answers, and it returns a single word per seed. Requests presented while the block is busy are used only to confirm that they are ignored. Their effect is checked at the ports, through later reads of the touched line.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_LOOKUP,
    ST_SEED,
    ST_WAIT
  } ctr_state_e;
endpackage

// File: rtl/ctr_minor_ram.sv
module ctr_minor_ram #(
  parameter int AW = 8,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctr_counter_bump.sv
module ctr_counter_bump #(
  parameter int MAJOR_W = 56,
  parameter int MINOR_W = 7
) (
  input  logic               bump,
  input  logic [MAJOR_W-1:0] major_in,
  input  logic [MINOR_W-1:0] minor_in,
  output logic [MAJOR_W-1:0] major_out,
  output logic [MINOR_W-1:0] minor_out,
  output logic               wrap
);
  always_comb begin
    major_out = major_in;
    minor_out = minor_in;
    wrap      = 1'b0;
    if (bump) begin
      if (&minor_in) begin
        wrap      = 1'b1;
        minor_out = '0;
        major_out = major_in + MAJOR_W'(1);
      end else begin
        minor_out = minor_in + MINOR_W'(1);
      end
    end
  end
endmodule

// File: rtl/ctr_ks_mixer.sv
module ctr_ks_mixer #(
  parameter int BLK_W = 128,
  parameter int BLKS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [BLK_W*BLKS-1:0]   data_in,
  input  logic                    apply,
  input  logic [$clog2(BLKS)-1:0] blk_sel,
  input  logic [BLK_W-1:0]        ks,
  output logic [BLK_W*BLKS-1:0]   data_out
);
  localparam int BIDX_W = $clog2(BLKS);

  for (genvar i = 0; i < BLKS; i++) begin : g_lane
    logic [BLK_W-1:0] lane;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane <= '0;
      end else if (load) begin
        lane <= data_in[i*BLK_W +: BLK_W];
      end else if (apply && blk_sel == BIDX_W'(i)) begin
        lane <= lane ^ ks;
      end
    end
    assign data_out[i*BLK_W +: BLK_W] = lane;
  end
endmodule

// File: rtl/ctr_line_crypt.sv
module ctr_line_crypt
  import ctr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int GROUP_W = 6,
  parameter int MINOR_W = 7,
  parameter int MAJOR_W = 56,
  parameter int BLK_W   = 128,
  parameter int BLKS    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [BLK_W*BLKS-1:0]                req_data,
  output logic                                 busy,
  output logic                                 seed_valid,
  input  logic                                 seed_ready,
  output logic [ADDR_W+MAJOR_W+MINOR_W+$clog2(BLKS)-1:0] seed_data,
  input  logic                                 ks_valid,
  input  logic [BLK_W-1:0]                     ks_data,
  output logic                                 out_valid,
  output logic                                 out_write,
  output logic [ADDR_W-1:0]                    out_addr,
  output logic [BLK_W*BLKS-1:0]                out_data,
  output logic                                 cnt_valid,
  output logic [ADDR_W-1:0]                    cnt_addr,
  output logic [MAJOR_W-1:0]                   cnt_major,
  output logic [MINOR_W-1:0]                   cnt_minor,
  output logic                                 regroup_valid,
  output logic [ADDR_W-GROUP_W-1:0]            regroup_group
);
  localparam int BIDX_W  = $clog2(BLKS);
  localparam int GRP_W   = ADDR_W - GROUP_W;
  localparam int NGROUPS = 1 << GRP_W;

  ctr_state_e          state;
  logic [ADDR_W-1:0]   addr_q;
  logic                write_q;
  logic [MAJOR_W-1:0]  maj_q;
  logic [MINOR_W-1:0]  min_q;
  logic [BIDX_W-1:0]   blk_q;
  logic                ovf_q;
  logic [ADDR_W-1:0]   clr_idx;
  logic [ADDR_W-1:0]   clr_end;
  logic [MAJOR_W-1:0]  major_r [NGROUPS];

  logic                accept;
  logic [GRP_W-1:0]    grp_q;
  logic [MINOR_W-1:0]  ram_rdata;
  logic                ram_we;
  logic [ADDR_W-1:0]   ram_waddr;
  logic [MINOR_W-1:0]  ram_wdata;
  logic [MAJOR_W-1:0]  nxt_maj;
  logic [MINOR_W-1:0]  nxt_min;
  logic                nxt_wrap;
  logic                last_blk;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign grp_q    = addr_q[ADDR_W-1 -: GRP_W];
  assign busy     = (state != ST_IDLE);
  assign last_blk = (blk_q == BIDX_W'(BLKS-1));

  // Minor counters: one write port (clear walk or bump), one registered read port
  assign ram_we    = (state == ST_CLEAR) || (state == ST_LOOKUP && write_q);
  assign ram_waddr = (state == ST_CLEAR) ? clr_idx : addr_q;
  assign ram_wdata = (state == ST_CLEAR) ? '0 : nxt_min;

  ctr_minor_ram #(.AW(ADDR_W), .DW(MINOR_W)) u_minor (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (req_addr),
    .rdata (ram_rdata)
  );

  ctr_counter_bump #(.MAJOR_W(MAJOR_W), .MINOR_W(MINOR_W)) u_bump (
    .bump      (write_q),
    .major_in  (major_r[grp_q]),
    .minor_in  (ram_rdata),
    .major_out (nxt_maj),
    .minor_out (nxt_min),
    .wrap      (nxt_wrap)
  );

  ctr_ks_mixer #(.BLK_W(BLK_W), .BLKS(BLKS)) u_mix (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .data_in  (req_data),
    .apply    (state == ST_WAIT && ks_valid),
    .blk_sel  (blk_q),
    .ks       (ks_data),
    .data_out (out_data)
  );

  assign seed_valid    = (state == ST_SEED);
  assign seed_data     = {addr_q, maj_q, min_q, blk_q};
  assign out_write     = write_q;
  assign out_addr      = addr_q;
  assign cnt_addr      = addr_q;
  assign cnt_major     = maj_q;
  assign cnt_minor     = min_q;
  assign regroup_group = grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_CLEAR;
      addr_q        <= '0;
      write_q       <= 1'b0;
      maj_q         <= '0;
      min_q         <= '0;
      blk_q         <= '0;
      ovf_q         <= 1'b0;
      clr_idx       <= '0;
      clr_end       <= '1;
      out_valid     <= 1'b0;
      cnt_valid     <= 1'b0;
      regroup_valid <= 1'b0;
      for (int g = 0; g < NGROUPS; g++) major_r[g] <= '0;
    end else begin
      out_valid     <= 1'b0;
      cnt_valid     <= 1'b0;
      regroup_valid <= 1'b0;
      unique case (state)
        ST_CLEAR: begin
          if (clr_idx == clr_end) state <= ST_IDLE;
          else clr_idx <= clr_idx + ADDR_W'(1);
        end
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            state   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          maj_q <= nxt_maj;
          min_q <= nxt_min;
          ovf_q <= nxt_wrap;
          if (nxt_wrap) major_r[grp_q] <= nxt_maj;
          blk_q <= '0;
          state <= ST_SEED;
        end
        ST_SEED: begin
          if (seed_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ks_valid) begin
            if (last_blk) begin
              out_valid     <= 1'b1;
              cnt_valid     <= write_q;
              regroup_valid <= ovf_q;
              if (ovf_q) begin
                clr_idx <= {grp_q, {GROUP_W{1'b0}}};
                clr_end <= {grp_q, {GROUP_W{1'b1}}};
                state   <= ST_CLEAR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              blk_q <= blk_q + BIDX_W'(1);
              state <= ST_SEED;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an offered seed is held until taken
  p_seed_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (seed_valid && !seed_ready) |=> (seed_valid && $stable(seed_data)));

  // R9: seeds are only offered while a request is in flight
  p_seed_busy_r9: assert property (@(posedge clk) disable iff (rst)
    seed_valid |-> busy);

  // R9: one single-cycle result per request
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: counter notification only alongside a write-back result
  p_cnt_with_out_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_valid |-> (out_valid && out_write));

  // R7: a regroup comes with a notification carrying minor zero
  p_regroup_min_r7: assert property (@(posedge clk) disable iff (rst)
    regroup_valid |-> (cnt_valid && cnt_minor == '0));

  // R3: a write-back without wrap never reports minor zero
  p_minor_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_valid && !regroup_valid) |-> (cnt_minor != '0));
endmodule

// File: tb/ctr_line_crypt_test.sv
`timescale 1ns/1ps
module ctr_line_crypt_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_write;
  logic [7:0]   req_addr;
  logic [511:0] req_data;
  logic         busy, seed_valid, seed_ready, ks_valid;
  logic [72:0]  seed_data;
  logic [127:0] ks_data;
  logic         out_valid, out_write, cnt_valid, regroup_valid;
  logic [7:0]   out_addr, cnt_addr;
  logic [511:0] out_data;
  logic [55:0]  cnt_major;
  logic [6:0]   cnt_minor;
  logic [1:0]   regroup_group;

  always #2.5 clk = ~clk;

  ctr_line_crypt uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data),
    .ks_valid(ks_valid), .ks_data(ks_data), .out_valid(out_valid),
    .out_write(out_write), .out_addr(out_addr), .out_data(out_data),
    .cnt_valid(cnt_valid), .cnt_addr(cnt_addr), .cnt_major(cnt_major),
    .cnt_minor(cnt_minor), .regroup_valid(regroup_valid),
    .regroup_group(regroup_group)
  );

  int total = 0;
  int bad   = 0;
  int seeds = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] ksf(input logic [72:0] s);
    return {s[54:0], s} ^ 128'h3c5a_96e1_0f87_d2b4_5a3c_e196_870f_b4d2;
  endfunction

  typedef struct {
    logic [511:0] data;
    logic [7:0]   addr;
    logic         wr;
    logic [55:0]  maj;
    logic [6:0]   mn;
    logic         rg;
  } exp_t;
  exp_t q[$];

  logic [6:0]  mmin [256];
  logic [55:0] mmaj [4];

  // Driver: computes the expected result from the requirements and queues it
  task automatic do_req(input logic wr, input logic [7:0] a, input logic [511:0] d);
    exp_t e;
    logic [1:0] g;
    while (busy) @(negedge clk);
    g = a[7:6];
    e.rg = 1'b0;
    if (wr) begin
      if (mmin[a] == 7'd127) begin
        mmaj[g]++;
        for (int k = 0; k < 64; k++) mmin[{g, 6'(k)}] = 7'd0;
        e.rg = 1'b1;
      end else begin
        mmin[a]++;
      end
    end
    e.maj = mmaj[g];
    e.mn  = mmin[a];
    e.addr = a;
    e.wr   = wr;
    for (int j = 0; j < 4; j++)
      e.data[128*j +: 128] = d[128*j +: 128] ^ ksf({a, e.maj, e.mn, 2'(j)});
    q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each result with the head of the queue
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected output", 512'(out_addr), 512'(0));
        end else begin
          e = q.pop_front();
          chk(out_data === e.data, "R5", "line data", out_data, e.data);
          chk(out_addr === e.addr && out_write === e.wr, "R9", "order addr/dir",
              512'({out_write, out_addr}), 512'({e.wr, e.addr}));
          if (e.wr) begin
            chk(cnt_valid === 1'b1 && cnt_addr === e.addr, "R6", "notify",
                512'({cnt_valid, cnt_addr}), 512'({1'b1, e.addr}));
            chk(cnt_major === e.maj && cnt_minor === e.mn, "R3", "counter used",
                512'({cnt_major, cnt_minor}), 512'({e.maj, e.mn}));
            chk(regroup_valid === e.rg, "R7", "regroup flag",
                512'(regroup_valid), 512'(e.rg));
            if (e.rg)
              chk(regroup_group === e.addr[7:6], "R7", "regroup group",
                  512'(regroup_group), 512'(e.addr[7:6]));
          end else begin
            chk(cnt_valid === 1'b0 && regroup_valid === 1'b0, "R4",
                "read raised notify", 512'({cnt_valid, regroup_valid}), 512'(0));
          end
        end
      end else if (!rst && (cnt_valid || regroup_valid)) begin
        chk(1'b0, "R6", "notify without output", 512'({cnt_valid, regroup_valid}), 512'(0));
      end
    end
  end

  // Cipher responder: varying stall and latency, one word per seed
  initial begin
    logic [72:0] s;
    seed_ready = 1'b0; ks_valid = 1'b0; ks_data = '0;
    forever begin
      @(negedge clk);
      if (!rst && seed_valid) begin
        s = seed_data;
        chk(s[1:0] === 2'(seeds % 4), "R2", "block index order",
            512'(s[1:0]), 512'(seeds % 4));
        for (int k = 0; k < seeds % 3; k++) begin
          @(negedge clk);
          chk(seed_valid === 1'b1 && seed_data === s, "R10", "seed held",
              512'(seed_data), 512'(s));
        end
        seed_ready = 1'b1;
        @(negedge clk);
        seed_ready = 1'b0;
        for (int k = 0; k < (seeds % 4); k++) begin
          chk(seed_valid === 1'b0, "R9", "second seed outstanding",
              512'(seed_valid), 512'(0));
          @(negedge clk);
        end
        seeds++;
        ks_data  = ksf(s);
        ks_valid = 1'b1;
        @(negedge clk);
        ks_valid = 1'b0;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [511:0] pa;
    for (int i = 0; i < 256; i++) mmin[i] = '0;
    for (int i = 0; i < 4; i++) mmaj[i] = '0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1 && out_valid === 1'b0 && seed_valid === 1'b0, "R1",
        "reset state", 512'({busy, out_valid, seed_valid}), 512'(3'b100));
    cyc = 1;
    while (busy && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc >= 256 && !busy, "R1", "clear walk length", 512'(cyc), 512'(256));

    pa = {16{32'hdead_beef}};
    do_req(1'b1, 8'd3, pa);             // R1/R3: minor 1
    do_req(1'b1, 8'd3, pa);             // R3: minor 2, fresh ciphertext
    do_req(1'b0, 8'd3, 512'h1234);      // R4: read with minor 2
    do_req(1'b0, 8'd3, 512'h1234);      // R4: unchanged
    do_req(1'b1, 8'd64, '0);            // R5: zeros
    do_req(1'b1, 8'd130, '1);           // R5: ones
    for (int k = 0; k < 3; k++)
      do_req(1'b1, 8'd255, {16{32'(k * 32'h0101_0101)}});

    // R9: requests while busy are ignored
    do_req(1'b0, 8'd64, 512'h55);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd200; req_data = '1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    do_req(1'b0, 8'd200, 512'h77);      // counter of line 200 still zero

    // R7: wrap group 0 through line 5
    for (int k = 0; k < 128; k++) do_req(1'b1, 8'd5, {16{32'(k)}});
    do_req(1'b0, 8'd7, 512'h99);        // R7: major 1 minor 0
    do_req(1'b0, 8'd3, 512'h98);        // R7: line 3 cleared
    do_req(1'b1, 8'd9, 512'h97);        // R7: major 1 minor 1
    do_req(1'b0, 8'd70, 512'h96);       // R8: group 1 untouched
    do_req(1'b1, 8'd130, 512'h95);      // R8: group 2 minor 2

    cyc = 0;
    while ((q.size() != 0 || busy) && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(q.size() == 0, "R9", "outputs outstanding", 512'(q.size()), 512'(0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule